// File: doc/BRIEF.md
# Six-Bit Binary to Two-Digit BCD Converter

This block turns a 6-bit unsigned binary value into two BCD digits, a units digit and a tens digit. Every input from 0 to 63 is covered. It is purely combinational and has no clock and no stored state. The outputs follow the present inputs only.

The conversion is a flat sum-of-products mapping taken from the full truth table. It is not an iterative shift-and-add-3 loop. Bit 0 of the input is wired straight to bit 0 of the units digit, because an odd input always gives an odd units digit. The upper five input bits feed one minterm decoder. Two OR planes read that decoder: one builds the upper three units bits and the other builds the tens digit.

An active-low enable gates the result. While the enable is released, every output bit is driven to 1. That pattern is not a valid BCD code, so a consumer can tell it apart from a converted value.

Top module: `bin2bcd6`

## Requirements
- R1: With `en_n_i` = 0, `units_o` equals `bin_i` mod 10 for every input value from 0 to 63.
- R2: With `en_n_i` = 0, `tens_o` equals `bin_i` div 10 for every input value from 0 to 63.
- R3: With `en_n_i` = 0, `units_o[0]` equals `bin_i[0]`.
- R4: With `en_n_i` = 1, `units_o` is 4'b1111 and `tens_o` is 3'b111, whatever `bin_i` holds.
- R5: With `en_n_i` = 0, `units_o` never exceeds 9 and `tens_o` never exceeds 6.
- R6: The block holds no state. After the enable is released and asserted again, or after a jump to any input value, the outputs depend only on the inputs present at that moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin_i | input | 6 | Unsigned binary value to convert |
| en_n_i | input | 1 | Active-low enable; when 1 the outputs carry the all-ones disabled code |
| units_o | output | 4 | BCD units digit |
| tens_o | output | 3 | BCD tens digit |

## Verification
No register sits between input and output. Every result is therefore due in the same time step as its stimulus, after combinational settling only, and no clock edge is involved. The bench applies each input pair and holds it for one minimum pulse time, set by the bench's clock-period localparam. It compares the outputs at the middle of that hold, well away from any change of the inputs. Expected digits come from a division and remainder computed in the bench.

// File: rtl/bcd6_pkg.sv
package bcd6_pkg;

    localparam int BIN_W   = 6;
    localparam int HALF_W  = BIN_W - 1;      // bits that enter the decoder
    localparam int TERMS   = 1 << HALF_W;    // minterms of the upper bits
    localparam int UNITS_W = 4;
    localparam int TENS_W  = 3;
    localparam int UHI_W   = UNITS_W - 1;    // units bits built by logic

    localparam logic [UNITS_W-1:0] UNITS_OFF = '1;
    localparam logic [TENS_W-1:0]  TENS_OFF  = '1;

    typedef struct packed {
        logic [UNITS_W-1:0] units;
        logic [TENS_W-1:0]  tens;
    } digits_t;

    // Value of output bit 'bitpos' for half-value k (N = 2k + lsb).
    // Units upper bits = k mod 5, tens = k div 5.
    function automatic logic term_bit(input int k, input int bitpos,
                                      input bit tens_sel);
        int v;
        v = tens_sel ? (k / 5) : (k % 5);
        return ((v >> bitpos) & 1) != 0;
    endfunction

    // OR-plane mask: which minterms feed a given output bit.
    function automatic logic [TERMS-1:0] plane_mask(input int bitpos,
                                                    input bit tens_sel);
        logic [TERMS-1:0] m;
        m = '0;
        for (int k = 0; k < TERMS; k++) begin
            m[k] = term_bit(k, bitpos, tens_sel);
        end
        return m;
    endfunction

endpackage

// File: rtl/bcd6_minterm_dec.sv
module bcd6_minterm_dec #(
    parameter int IN_W  = 5,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  sel_i,
    output logic [OUT_N-1:0] hit_o
);

    // One AND term per input combination: each literal taken true or inverted.
    for (genvar t = 0; t < OUT_N; t++) begin : g_term
        localparam logic [IN_W-1:0] PAT = t[IN_W-1:0];
        assign hit_o[t] = &(sel_i ~^ PAT);
    end

endmodule

// File: rtl/bcd6_or_plane.sv
module bcd6_or_plane #(
    parameter int TERMS    = 32,
    parameter int OUT_W    = 3,
    parameter bit TENS_SEL = 1'b0
) (
    input  logic [TERMS-1:0] hit_i,
    output logic [OUT_W-1:0] y_o
);

    for (genvar o = 0; o < OUT_W; o++) begin : g_bit
        localparam logic [TERMS-1:0] MASK = bcd6_pkg::plane_mask(o, TENS_SEL);
        assign y_o[o] = |(hit_i & MASK);
    end

endmodule

// File: rtl/bcd6_out_stage.sv
module bcd6_out_stage
    import bcd6_pkg::*;
(
    input  logic               en_n_i,
    input  logic               lsb_i,
    input  logic [UHI_W-1:0]   units_hi_i,
    input  logic [TENS_W-1:0]  tens_i,
    output logic [UNITS_W-1:0] units_o,
    output logic [TENS_W-1:0]  tens_o
);

    digits_t out_d;

    always_comb begin
        out_d.units = {units_hi_i, lsb_i};
        out_d.tens  = tens_i;
        if (en_n_i) begin
            out_d.units = UNITS_OFF;
            out_d.tens  = TENS_OFF;
        end
    end

    assign units_o = out_d.units;
    assign tens_o  = out_d.tens;

endmodule

// File: rtl/bin2bcd6.sv
module bin2bcd6
    import bcd6_pkg::*;
(
    input  logic [BIN_W-1:0]   bin_i,
    input  logic               en_n_i,
    output logic [UNITS_W-1:0] units_o,
    output logic [TENS_W-1:0]  tens_o
);

    logic [TERMS-1:0]  hit;
    logic [UHI_W-1:0]  units_hi;
    logic [TENS_W-1:0] tens_raw;

    bcd6_minterm_dec #(.IN_W(HALF_W)) u_dec (
        .sel_i (bin_i[BIN_W-1:1]),
        .hit_o (hit)
    );

    bcd6_or_plane #(.TERMS(TERMS), .OUT_W(UHI_W), .TENS_SEL(1'b0)) u_units_plane (
        .hit_i (hit),
        .y_o   (units_hi)
    );

    bcd6_or_plane #(.TERMS(TERMS), .OUT_W(TENS_W), .TENS_SEL(1'b1)) u_tens_plane (
        .hit_i (hit),
        .y_o   (tens_raw)
    );

    bcd6_out_stage u_out (
        .en_n_i     (en_n_i),
        .lsb_i      (bin_i[0]),
        .units_hi_i (units_hi),
        .tens_i     (tens_raw),
        .units_o    (units_o),
        .tens_o     (tens_o)
    );

endmodule

// File: rtl/bcd6_checker.sv
module bcd6_checker (
    input logic [5:0] bin_i,
    input logic       en_n_i,
    input logic [3:0] units_o,
    input logic [2:0] tens_o
);

    int recon;

    always_comb begin
        recon = int'(units_o) + 10 * int'(tens_o);
        // R1 and R2: the two digits rebuild the input
        assert_digits_rebuild_R1: assert (en_n_i || recon == int'(bin_i))
            else $error("digits do not rebuild input");
        assert_tens_match_R2: assert (en_n_i || int'(tens_o) == int'(bin_i) / 10)
            else $error("tens digit wrong");
        assert_lsb_pass_R3: assert (en_n_i || units_o[0] == bin_i[0])
            else $error("lsb not passed through");
        assert_off_code_R4: assert (!en_n_i || (units_o == 4'hF && tens_o == 3'h7))
            else $error("disabled code wrong");
        assert_digit_range_R5: assert (en_n_i || (units_o <= 4'd9 && tens_o <= 3'd6))
            else $error("digit out of range");
    end

endmodule

bind bin2bcd6 bcd6_checker u_chk (
    .bin_i   (bin_i),
    .en_n_i  (en_n_i),
    .units_o (units_o),
    .tens_o  (tens_o)
);

// File: tb/bin2bcd6_tb.sv
module bin2bcd6_tb;

    localparam int CLK_PERIOD = 10;   // minimum pulse time per stimulus

    logic [5:0] bin;
    logic       en_n;
    logic [3:0] units;
    logic [2:0] tens;
    logic       clk;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    bin2bcd6 u_dut (
        .bin_i   (bin),
        .en_n_i  (en_n),
        .units_o (units),
        .tens_o  (tens)
    );

    initial clk = 0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s bin=%0d en_n=%0d actual=%0d expected=%0d",
                     req, bin, en_n, act, exp);
        end
    endtask

    // Hold the inputs for one pulse, sample in the middle, finish the pulse.
    task automatic apply(input int v, input logic dis);
        bin  = v[5:0];
        en_n = dis;
        #(CLK_PERIOD / 2);
    endtask

    task automatic check_enabled(input int v);
        apply(v, 1'b0);
        chk("R1", int'(units), v % 10);
        chk("R2", int'(tens), v / 10);
        chk("R3", int'(units[0]), v % 2);
        chk("R5", int'(units <= 4'd9 && tens <= 3'd6), 1);
        #(CLK_PERIOD / 2);
    endtask

    task automatic check_disabled(input int v);
        apply(v, 1'b1);
        chk("R4", int'(units), 15);
        chk("R4", int'(tens), 7);
        #(CLK_PERIOD / 2);
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'h1b2c3));
        bin  = '0;
        en_n = 1'b1;
        #(CLK_PERIOD);
        // power-up state with enable released
        check_disabled(0);
        // full sweep, enabled: R1 R2 R3 R5
        for (int v = 0; v < 64; v++) check_enabled(v);
        // directed corners across digit boundaries
        check_enabled(9);
        check_enabled(10);
        check_enabled(59);
        check_enabled(60);
        check_enabled(63);
        // disabled code on several inputs: R4
        check_disabled(63);
        check_disabled(37);
        check_disabled(1);
        // R6: jumps and enable toggles leave no memory
        check_enabled(47);
        check_disabled(47);
        check_enabled(47);
        check_enabled(0);
        check_enabled(63);
        // constrained random mix
        for (int i = 0; i < 200; i++) begin
            int v;
            v = int'($urandom_range(63, 0));
            if ($urandom_range(3, 0) == 0) check_disabled(v);
            else begin
                check_enabled(v);
                chk("R6", int'(units) + 10 * int'(tens), v);
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule